// File: doc/BRIEF.md
# Synchronous Serial Clock Front End and Receive Sampler

This block produces the bit clock and the receive sampling for a clocked serial link. It can work in two ways. In the first, it drives the serial clock pin itself. One of four rate sources is selected, and every tick from that source toggles the pin, so the pin runs at half the tick rate. In the second, the pin is an input. A synchronized copy of the external clock is watched for either its rising or its falling edge.

In both cases one internal strobe, `sampleStb`, marks the moment a receive bit is taken. In output mode that moment is the rising edge of the driven clock. In input mode it is the selected edge of the external clock. Sampled bits go into a byte register, least significant bit first. After the eighth bit, a one-cycle `byteDone` pulse presents the byte.

Changing the source, direction or edge selection while the block is enabled restarts the divider and the bit count. The same restart happens while the block is disabled. The driven clock rests high whenever it is idle.

Top module: `syncser_front`

## Requirements
- R1: After reset, `sclkOut` is 1 and `sampleStb`, `byteDone` and `rxByte` are all 0.
- R2: With `srcSel`=0 in output mode (`clkDir`=0), each cycle with `baudTick` high toggles `sclkOut` at the next clock edge.
- R3: With `srcSel`=1 in output mode, the source is the system clock divided by two, so `sclkOut` toggles every 2 cycles and a bit is sampled every 4 cycles.
- R4: With `srcSel`=2 in output mode, each cycle with `timerTick` high toggles `sclkOut`.
- R5: With `srcSel`=3 in output mode, each rising edge of `extClkIn` toggles `sclkOut`, after a two-flop synchronizer.
- R6: In output mode a bit is sampled only when `sclkOut` goes from 0 to 1, and `sampleStb` is high in the same cycle that `sclkOut` first reads 1.
- R7: In input mode (`clkDir`=1), `edgeSel`=0 samples on rising edges of `sclkIn` and `edgeSel`=1 samples on falling edges. `sampleStb` goes high at the third clock edge after the pin changes.
- R8: In input mode `sclkOut` stays 1 and the tick sources have no effect. In output mode `sclkIn` has no effect.
- R9: Bits enter `rxByte` least significant bit first. On the eighth sample, `byteDone` is high for exactly one cycle, in the same cycle as that `sampleStb`, with the complete byte on `rxByte`.
- R10: A change of `srcSel`, `clkDir` or `edgeSel` while enabled drives `sclkOut` to 1 at the next edge, resets the divider, and discards any partial byte.
- R11: While `enable` is 0, `sclkOut` is 1 and no sample is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Run enable; low holds the block idle |
| srcSel | input | 2 | Rate source: 0 baud tick, 1 system/2, 2 timer tick, 3 external clock |
| clkDir | input | 1 | 0 drives the serial clock, 1 accepts an external serial clock |
| edgeSel | input | 1 | Input mode sampling edge: 0 rising, 1 falling |
| baudTick | input | 1 | Single-cycle tick from the baud-rate generator |
| timerTick | input | 1 | Single-cycle tick from a timer |
| extClkIn | input | 1 | Asynchronous external rate clock |
| sclkIn | input | 1 | Serial clock pin input, used in input mode |
| rxdIn | input | 1 | Asynchronous serial receive data |
| sclkOut | output | 1 | Serial clock pin value, idle high |
| sampleStb | output | 1 | One-cycle pulse per sampled bit |
| rxByte | output | 8 | Last completed received byte |
| byteDone | output | 1 | One-cycle pulse when `rxByte` is updated |

## Verification
A baud or timer tick shows on `sclkOut` one edge after the tick. An `extClkIn` edge shows three edges after it is applied. A `sclkIn` edge raises `sampleStb` at the third edge. `byteDone` always arrives in the same cycle as the eighth `sampleStb`.

The bench changes inputs on falling clock edges and reads outputs on the following falling edges. Directed checks count exactly those edges. Whole-byte checks instead space source events at least four cycles apart and allow a margin after the last event. Receive data advances only after each observed strobe, so that bits stay aligned with the two-flop data synchronizer.

// File: rtl/syncser_pkg.sv
`timescale 1ns/1ps
package syncser_pkg;
  typedef enum logic [1:0] {
    SRC_BAUD    = 2'd0,
    SRC_SYSHALF = 2'd1,
    SRC_TIMER   = 2'd2,
    SRC_EXT     = 2'd3
  } clkSrc_t;

  typedef struct packed {
    logic shiftEn;
    logic clearCnt;
    logic bitVal;
  } serStrobes_t;
endpackage

// File: rtl/syncser_sync.sv
`timescale 1ns/1ps
module syncser_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) chain[i] <= 1'b0;
          else       chain[i] <= din;
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) chain[i] <= 1'b0;
          else       chain[i] <= chain[i-1];
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/syncser_ctrl.sv
`timescale 1ns/1ps
module syncser_ctrl
  import syncser_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        enable,
  input  logic [1:0]  srcSel,
  input  logic        clkDir,
  input  logic        edgeSel,
  input  logic        baudTick,
  input  logic        timerTick,
  input  logic        extClkIn,
  input  logic        sclkIn,
  input  logic        rxdIn,
  output logic        sclkOut,
  output logic        sampleStb,
  output serStrobes_t strobes
);
  localparam int CFG_W = 4;

  logic extSync, sclSync, rxdSync;
  logic extPrev, sclPrev;
  logic half, sclkReg;
  logic [CFG_W-1:0] cfgQ, cfgNow;
  logic cfgChange, restart, srcTick, outToggle, inEdge;

  syncser_sync #(.STAGES(SYNC_STAGES)) i_syncExt (.clk(clk), .rstN(rstN), .din(extClkIn), .dout(extSync));
  syncser_sync #(.STAGES(SYNC_STAGES)) i_syncScl (.clk(clk), .rstN(rstN), .din(sclkIn),   .dout(sclSync));
  syncser_sync #(.STAGES(SYNC_STAGES)) i_syncRxd (.clk(clk), .rstN(rstN), .din(rxdIn),    .dout(rxdSync));

  assign cfgNow    = {srcSel, clkDir, edgeSel};
  assign cfgChange = enable && (cfgNow != cfgQ);
  assign restart   = !enable || cfgChange;

  always_comb begin
    unique case (clkSrc_t'(srcSel))
      SRC_BAUD:    srcTick = baudTick;
      SRC_SYSHALF: srcTick = half;
      SRC_TIMER:   srcTick = timerTick;
      SRC_EXT:     srcTick = extSync & ~extPrev;
      default:     srcTick = 1'b0;
    endcase
  end

  assign outToggle = !restart && !clkDir && srcTick;
  assign inEdge    = edgeSel ? (sclPrev & ~sclSync) : (sclSync & ~sclPrev);

  always_comb begin
    strobes.clearCnt = restart;
    strobes.bitVal   = rxdSync;
    strobes.shiftEn  = !restart && (clkDir ? inEdge : (outToggle && !sclkReg));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ      <= '0;
      extPrev   <= 1'b0;
      sclPrev   <= 1'b0;
      half      <= 1'b0;
      sclkReg   <= 1'b1;
      sampleStb <= 1'b0;
    end else begin
      cfgQ      <= cfgNow;
      extPrev   <= extSync;
      sclPrev   <= sclSync;
      sampleStb <= strobes.shiftEn;
      if (restart) begin
        half    <= 1'b0;
        sclkReg <= 1'b1;
      end else begin
        half <= ~half;
        if (outToggle) sclkReg <= ~sclkReg;
      end
    end
  end

  assign sclkOut = sclkReg;

  a_r11_idle_high: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> sclkOut && !sampleStb);
  a_r6_stb_on_rise: assert property (@(posedge clk) disable iff (!rstN)
    sampleStb && !$past(clkDir) |-> sclkOut && !$past(sclkOut));
  a_r10_cfg_restart: assert property (@(posedge clk) disable iff (!rstN)
    cfgChange |=> sclkOut && !sampleStb);
  a_r8_input_mode_high: assert property (@(posedge clk) disable iff (!rstN)
    clkDir |=> sclkOut);
endmodule

// File: rtl/syncser_dpath.sv
`timescale 1ns/1ps
module syncser_dpath
  import syncser_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  serStrobes_t       strobes,
  output logic [DATA_W-1:0] rxByte,
  output logic              byteDone
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic [DATA_W-1:0] shiftReg, shiftNext;
  logic [CNT_W-1:0]  bitCnt;

  assign shiftNext = {strobes.bitVal, shiftReg[DATA_W-1:1]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      bitCnt   <= '0;
      rxByte   <= '0;
      byteDone <= 1'b0;
    end else begin
      byteDone <= 1'b0;
      if (strobes.clearCnt) begin
        bitCnt <= '0;
      end else if (strobes.shiftEn) begin
        shiftReg <= shiftNext;
        if (bitCnt == LAST) begin
          bitCnt   <= '0;
          rxByte   <= shiftNext;
          byteDone <= 1'b1;
        end else begin
          bitCnt <= bitCnt + 1'b1;
        end
      end
    end
  end

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rstN)
    byteDone |=> !byteDone);
  a_r10_clear_no_done: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clearCnt |=> !byteDone);
endmodule

// File: rtl/syncser_front.sv
`timescale 1ns/1ps
module syncser_front
  import syncser_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic [1:0]        srcSel,
  input  logic              clkDir,
  input  logic              edgeSel,
  input  logic              baudTick,
  input  logic              timerTick,
  input  logic              extClkIn,
  input  logic              sclkIn,
  input  logic              rxdIn,
  output logic              sclkOut,
  output logic              sampleStb,
  output logic [DATA_W-1:0] rxByte,
  output logic              byteDone
);
  serStrobes_t strobes;

  syncser_ctrl #(.SYNC_STAGES(SYNC_STAGES)) i_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .srcSel(srcSel), .clkDir(clkDir),
    .edgeSel(edgeSel), .baudTick(baudTick), .timerTick(timerTick),
    .extClkIn(extClkIn), .sclkIn(sclkIn), .rxdIn(rxdIn),
    .sclkOut(sclkOut), .sampleStb(sampleStb), .strobes(strobes)
  );

  syncser_dpath #(.DATA_W(DATA_W)) i_dpath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .rxByte(rxByte), .byteDone(byteDone)
  );

  a_r9_done_with_stb: assert property (@(posedge clk) disable iff (!rstN)
    byteDone |-> sampleStb);
endmodule

// File: tb/test_syncser_front.sv
`timescale 1ns/1ps
module test_syncser_front;
  logic clk = 1'b0, rstN = 1'b0, enable = 1'b0;
  logic [1:0] srcSel = 2'd0;
  logic clkDir = 1'b0, edgeSel = 1'b0, baudTick = 1'b0, timerTick = 1'b0;
  logic extClkIn = 1'b0, sclkIn = 1'b0;
  logic rxdIn, sclkOut, sampleStb, byteDone;
  logic [7:0] rxByte, txWord = 8'h00, lastByte = 8'h00;
  logic [2:0] bitIdx;
  int stbCount = 0, doneCount = 0, baseStb = 0, baseDone = 0;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  syncser_front i_syncser_front (
    .clk(clk), .rstN(rstN), .enable(enable), .srcSel(srcSel), .clkDir(clkDir),
    .edgeSel(edgeSel), .baudTick(baudTick), .timerTick(timerTick),
    .extClkIn(extClkIn), .sclkIn(sclkIn), .rxdIn(rxdIn),
    .sclkOut(sclkOut), .sampleStb(sampleStb), .rxByte(rxByte), .byteDone(byteDone)
  );

  assign bitIdx = 3'(stbCount - baseStb);
  assign rxdIn  = txWord[bitIdx];

  always @(negedge clk) begin
    if (sampleStb) stbCount++;
    if (byteDone) begin
      doneCount++;
      lastByte = rxByte;
    end
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseBaud();
    baudTick = 1'b1; waitN(1); baudTick = 1'b0; waitN(3);
  endtask

  task automatic pulseTimer();
    timerTick = 1'b1; waitN(1); timerTick = 1'b0; waitN(3);
  endtask

  function automatic string reqOf(input logic [1:0] s, input logic d);
    if (d) return "R7";
    case (s)
      2'd0: return "R2";
      2'd1: return "R3";
      2'd2: return "R4";
      default: return "R5";
    endcase
  endfunction

  // {srcSel, clkDir, edgeSel, word}
  localparam int NVEC = 6;
  localparam logic [11:0] VEC [NVEC] = '{
    {2'd0, 1'b0, 1'b0, 8'hA5},
    {2'd1, 1'b0, 1'b0, 8'h3C},
    {2'd2, 1'b0, 1'b0, 8'h81},
    {2'd3, 1'b0, 1'b0, 8'h5E},
    {2'd0, 1'b1, 1'b0, 8'hC3},
    {2'd0, 1'b1, 1'b1, 8'h17}
  };

  task automatic runWord(input logic [1:0] s, input logic d, input logic e, input logic [7:0] w);
    string r;
    r = reqOf(s, d);
    txWord = w; baseStb = stbCount; baseDone = doneCount;
    srcSel = s; clkDir = d; edgeSel = e; enable = 1'b1;
    if (d) begin
      waitN(2);
      for (int i = 0; i < 16; i++) begin sclkIn = ~sclkIn; waitN(4); end
    end else if (s == 2'd1) begin
      waitN(34);
    end else begin
      waitN(2);
      for (int i = 0; i < 16; i++) begin
        if (s == 2'd0) pulseBaud();
        else if (s == 2'd2) pulseTimer();
        else begin extClkIn = 1'b1; waitN(4); extClkIn = 1'b0; waitN(4); end
      end
      waitN(2);
    end
    enable = 1'b0;
    waitN(3);
    check(lastByte == w, r, "byte value LSB first (R9)", lastByte, w);
    check(stbCount - baseStb == 8, r, "sample count", stbCount - baseStb, 8);
    check(doneCount - baseDone == 1, "R9", "byteDone pulses", doneCount - baseDone, 1);
  endtask

  initial begin
    #(200000 * 4);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int b;
    waitN(3);
    rstN = 1'b1;
    waitN(1);
    check(sclkOut == 1'b1, "R1", "sclkOut after reset", sclkOut, 1);
    check(sampleStb == 1'b0, "R1", "sampleStb after reset", sampleStb, 0);
    check(byteDone == 1'b0, "R1", "byteDone after reset", byteDone, 0);
    check(rxByte == 8'h00, "R1", "rxByte after reset", rxByte, 0);

    // R2 / R6 latency, output mode on baud ticks
    srcSel = 2'd0; clkDir = 1'b0; edgeSel = 1'b0; enable = 1'b1;
    waitN(2);
    baudTick = 1'b1; waitN(1); baudTick = 1'b0;
    check(sclkOut == 1'b0, "R2", "sclkOut after first tick", sclkOut, 0);
    check(sampleStb == 1'b0, "R6", "no sample on falling", sampleStb, 0);
    waitN(2);
    baudTick = 1'b1; waitN(1); baudTick = 1'b0;
    check(sclkOut == 1'b1 && sampleStb == 1'b1, "R6", "stb with rising sclk", {sclkOut, sampleStb}, 3);
    waitN(1);
    check(sampleStb == 1'b0, "R6", "stb single cycle", sampleStb, 0);
    // R8: sclkIn ignored in output mode
    b = stbCount;
    for (int i = 0; i < 6; i++) begin sclkIn = ~sclkIn; waitN(4); end
    check(stbCount == b && sclkOut == 1'b1, "R8", "sclkIn ignored in output mode", stbCount - b, 0);
    // R10: config change forces sclk high
    pulseBaud();
    check(sclkOut == 1'b0, "R2", "sclkOut low after tick", sclkOut, 0);
    srcSel = 2'd2; waitN(1);
    check(sclkOut == 1'b1, "R10", "sclkOut high after source change", sclkOut, 1);
    // R11: disabled
    enable = 1'b0; waitN(2);
    b = stbCount;
    for (int i = 0; i < 4; i++) pulseTimer();
    check(sclkOut == 1'b1 && stbCount == b, "R11", "disabled stays idle", {sclkOut, 1'b0} | (stbCount - b), 2);

    // R7 latency, input mode rising
    sclkIn = 1'b0; srcSel = 2'd0; clkDir = 1'b1; edgeSel = 1'b0; enable = 1'b1;
    waitN(4);
    b = stbCount;
    sclkIn = 1'b1; waitN(1);
    check(sampleStb == 1'b0, "R7", "stb after 1 edge", sampleStb, 0);
    waitN(1);
    check(sampleStb == 1'b0, "R7", "stb after 2 edges", sampleStb, 0);
    waitN(1);
    check(sampleStb == 1'b1, "R7", "stb after 3 edges", sampleStb, 1);
    check(sclkOut == 1'b1, "R8", "sclkOut high in input mode", sclkOut, 1);
    waitN(2);
    sclkIn = 1'b0; waitN(4);
    check(stbCount - b == 1, "R7", "no sample on falling when rising selected", stbCount - b, 1);
    pulseBaud(); pulseBaud();
    check(stbCount - b == 1, "R8", "ticks ignored in input mode", stbCount - b, 1);
    // R10: partial byte discarded on edge change
    for (int i = 0; i < 2; i++) begin sclkIn = 1'b1; waitN(4); sclkIn = 1'b0; waitN(4); end
    txWord = 8'h6D; baseStb = stbCount; baseDone = doneCount;
    edgeSel = 1'b1; waitN(2);
    for (int i = 0; i < 16; i++) begin sclkIn = ~sclkIn; waitN(4); end
    check(doneCount - baseDone == 1, "R10", "one byte after restart", doneCount - baseDone, 1);
    check(lastByte == 8'h6D, "R10", "partial bits discarded", lastByte, 8'h6D);
    enable = 1'b0; sclkIn = 1'b0; waitN(4);

    for (int v = 0; v < NVEC; v++)
      runWord(VEC[v][11:10], VEC[v][9], VEC[v][8], VEC[v][7:0]);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule